// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block switches the enables of four supply rails (channels A to D) on and off in a set order. A high level on the sequence enable input starts power-up. After a fixed pre-start wait, each channel counts its own turn-on delay and then asserts its gate enable. Dropping the enable starts a power-down: each channel counts its own turn-off delay, and its gate enable falls when that delay ends. A channel whose gate never came on before the power-down stays off. Every delay is counted in ticks of a shared clock prescaler. The analog behaviour is reduced to counters and a per-channel "gate fully on" indication.

Each rail has an undervoltage-good input, and this input is deglitched before the controller acts on it. When all rails first become good, a lockout window opens and the enable is ignored until it closes. The reset output is held low until every gate reports fully on and a settle time has passed. It drops again as soon as the enable goes low, a rail fails or the shared system reset line is pulled down.

The system reset line is shared by several controllers and is modelled as a level input plus a pull-down output. The controller pulls the line low while a rail fault lasts. A low line switches every gate off at once. When the line rises again with the enable high, power-up starts immediately, without the lockout window or the pre-start wait.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until the rails are good, all four gate enables are 0, `rst_out_n_o` is 0 and `sysrst_pull_o` is 1.
- R2: A rail input that drops for fewer than GLITCH_TICKS ticks changes no output. A drop that lasts GLITCH_TICKS ticks or more is a fault: every gate enable goes to 0 within one cycle after the fault is recognised.
- R3: After all rail inputs become good, a high enable has no effect for LOCKOUT_TICKS ticks. No gate enable rises inside that window.
- R4: Once the enable is accepted, the controller waits LOCKOUT_TICKS ticks and then starts every channel's turn-on count. Channel i (bit i of `gate_en_o`; A is bit 0) rises when its count reaches `on_dly_i[16*i +: 16]` ticks, so channels with larger delays rise later.
- R5: A falling enable starts every channel's turn-off count. A channel that is on falls after `off_dly_i[16*i +: 16]` ticks, so the turn-off order follows the turn-off delays.
- R6: A falling enable in the middle of power-up cancels the turn-on counts still running. Channels that are not yet on stay off for the whole power-down.
- R7: `rst_out_n_o` rises SETTLE_TICKS ticks after every `gate_full_i` bit is 1 with the sequence complete, and never before all gate enables are 1.
- R8: `rst_out_n_o` is 0 on the clock edge after the enable is seen low or a rail fault is recognised.
- R9: A low level on `sysrst_line_i` sets every gate enable to 0 on the next clock edge, with no turn-off delays. The gates stay 0 for as long as the line is low.
- R10: A rising edge on `sysrst_line_i` while the enable is high and all rails are good starts the turn-on counts at once, without the lockout window or the pre-start wait.
- R11: `sysrst_pull_o` is 1 while any deglitched rail input reports a fault and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en_i | input | 1 | Sequence enable, active high |
| uv_ok_i | input | NCH | Rail undervoltage-good inputs; bit i is channel i |
| sysrst_line_i | input | 1 | Level of the shared system reset line; low means latch-off |
| on_dly_i | input | NCH*16 | Turn-on delays in ticks; channel i in bits [16*i +: 16] |
| off_dly_i | input | NCH*16 | Turn-off delays in ticks; channel i in bits [16*i +: 16] |
| gate_full_i | input | NCH | Gate fully on indication, one bit per channel |
| gate_en_o | output | NCH | Gate enable outputs; bit i is channel i |
| sysrst_pull_o | output | 1 | Pulls the shared reset line low when 1 (rail fault) |
| rst_out_n_o | output | 1 | Reset output, low while asserted |

## Verification
A wrong sequencer state shows up at the gate enables within a few ticks. A gate rises too early or out of order, or a cancelled channel rises during power-down. A wrong settle counter shows up as a reset release that comes too early or never comes, measured against the last gate rise. A filter or line handling fault is visible within one clock: gates that stay on while the line is low, or gates that drop on a short dip. A missed bypass shows up as a power-up delayed by a full pre-start wait.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int DLY_W = 16;
  typedef logic [DLY_W-1:0] dly_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_RAMP,
    SQ_UP,
    SQ_FALL
  } seq_st_e;

  // true once a channel's elapsed tick count has met its programmed delay
  function automatic logic dly_reached(dly_t elapsed, dly_t target);
    return elapsed >= target;
  endfunction

  // one step of a saturating tick counter
  function automatic dly_t dly_advance(dly_t elapsed, logic tick);
    if (tick && (elapsed != '1)) return elapsed + dly_t'(1);
    return elapsed;
  endfunction
endpackage

// File: rtl/rail_tick_gen.sv
module rail_tick_gen #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_cnt <= '0;
    else if (div_cnt == W'(DIV-1))  div_cnt <= '0;
    else                            div_cnt <= div_cnt + W'(1);
  end

  assign tick_o = (div_cnt == W'(DIV-1));
endmodule

// File: rtl/rail_uv_filter.sv
module rail_uv_filter #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_ok_i,
  output logic ok_o
);
  localparam int W = $clog2(HOLD + 2);

  logic [W-1:0] bad_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_cnt <= '0;
      ok_o    <= 1'b0;
    end else if (raw_ok_i) begin
      bad_cnt <= '0;
      ok_o    <= 1'b1;
    end else if (bad_cnt >= W'(HOLD)) begin
      ok_o    <= 1'b0;
    end else if (tick_i) begin
      bad_cnt <= bad_cnt + W'(1);
    end
  end

  // R2: the filtered flag only falls while the raw input is bad
  p_fall_needs_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ok_o) |-> !$past(raw_ok_i)));

  // R2: a good raw input is reported good on the next edge
  p_good_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_ok_i |=> ok_o));
endmodule

// File: rtl/rail_channel.sv
module rail_channel
  import rail_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic kill_i,
  input  dly_t on_dly_i,
  input  dly_t off_dly_i,
  output logic gate_o
);
  dly_t elapsed;
  logic reached;

  assign reached = rise_en_i ? dly_reached(elapsed, on_dly_i)
                             : dly_reached(elapsed, off_dly_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     elapsed <= '0;
    else if (clr_i) elapsed <= '0;
    else            elapsed <= dly_advance(elapsed, tick_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gate_o <= 1'b0;
    else if (kill_i)                 gate_o <= 1'b0;
    else if (rise_en_i && reached)   gate_o <= 1'b1;
    else if (fall_en_i && reached)   gate_o <= 1'b0;
  end

  // R6: during power-down an off gate never comes on
  p_fall_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_en_i && !gate_o |=> !gate_o));

  // R4: during power-up an on gate stays on unless killed
  p_rise_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en_i && !fall_en_i && !kill_i && gate_o |=> gate_o));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int PRESCALE      = 500,
  parameter int LOCKOUT_TICKS = 1000,
  parameter int SETTLE_TICKS  = 15000,
  parameter int GLITCH_TICKS  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_en_i,
  input  logic [NCH-1:0]     uv_ok_i,
  input  logic               sysrst_line_i,
  input  logic [NCH*DLY_W-1:0] on_dly_i,
  input  logic [NCH*DLY_W-1:0] off_dly_i,
  input  logic [NCH-1:0]     gate_full_i,
  output logic [NCH-1:0]     gate_en_o,
  output logic               sysrst_pull_o,
  output logic               rst_out_n_o
);
  localparam int LCW = $clog2(LOCKOUT_TICKS + 2);
  localparam int SCW = $clog2(SETTLE_TICKS + 2);

  logic           tick;
  logic [NCH-1:0] uv_good;
  logic           all_ok, all_ok_q, ok_rise;
  logic           line_q, line_rise;
  logic           kill;
  logic [LCW-1:0] lock_cnt, hold_cnt;
  logic           lockout;
  logic [SCW-1:0] settle_cnt;
  logic           settle_cond;
  seq_st_e        state, nxt;
  logic           clr_q, rise_en, fall_en, all_on, any_on;

  rail_tick_gen #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_rail
    rail_uv_filter #(.HOLD(GLITCH_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .raw_ok_i(uv_ok_i[g]), .ok_o(uv_good[g])
    );
    rail_channel u_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(clr_q),
      .rise_en_i(rise_en), .fall_en_i(fall_en), .kill_i(kill),
      .on_dly_i(on_dly_i[g*DLY_W +: DLY_W]),
      .off_dly_i(off_dly_i[g*DLY_W +: DLY_W]),
      .gate_o(gate_en_o[g])
    );
  end

  assign all_ok    = &uv_good;
  assign ok_rise   = all_ok & ~all_ok_q;
  assign line_rise = sysrst_line_i & ~line_q;
  assign kill      = ~sysrst_line_i | ~all_ok;
  assign lockout   = (lock_cnt != '0);
  assign all_on    = &gate_en_o;
  assign any_on    = |gate_en_o;
  assign rise_en   = ((state == SQ_RAMP) || (state == SQ_UP)) && !clr_q;
  assign fall_en   = (state == SQ_FALL) && !clr_q;

  always_comb begin
    nxt = state;
    if (kill)                          nxt = SQ_IDLE;
    else if (line_rise && seq_en_i)    nxt = SQ_RAMP;
    else begin
      case (state)
        SQ_IDLE: if (seq_en_i && !lockout) nxt = SQ_HOLD;
        SQ_HOLD: if (!seq_en_i)            nxt = SQ_IDLE;
                 else if (hold_cnt == '0)  nxt = SQ_RAMP;
        SQ_RAMP: if (!seq_en_i)            nxt = SQ_FALL;
                 else if (all_on)          nxt = SQ_UP;
        SQ_UP:   if (!seq_en_i)            nxt = SQ_FALL;
        SQ_FALL: if (!any_on)              nxt = SQ_IDLE;
        default:                           nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      clr_q    <= 1'b0;
      all_ok_q <= 1'b0;
      line_q   <= 1'b1;
      sysrst_pull_o <= 1'b1;
    end else begin
      state    <= nxt;
      clr_q    <= (nxt != state) && ((nxt == SQ_RAMP) || (nxt == SQ_FALL));
      all_ok_q <= all_ok;
      line_q   <= sysrst_line_i;
      sysrst_pull_o <= ~all_ok;
    end
  end

  // start-up lockout window and pre-start wait, both in ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
      hold_cnt <= '0;
    end else begin
      if (ok_rise)                      lock_cnt <= LCW'(LOCKOUT_TICKS);
      else if (tick && lockout)         lock_cnt <= lock_cnt - LCW'(1);
      if (nxt == SQ_HOLD && state != SQ_HOLD) hold_cnt <= LCW'(LOCKOUT_TICKS);
      else if (tick && hold_cnt != '0)  hold_cnt <= hold_cnt - LCW'(1);
    end
  end

  // delayed reset release once every gate reports fully on
  assign settle_cond = (state == SQ_UP) && (&gate_full_i) && seq_en_i && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt  <= SCW'(SETTLE_TICKS);
      rst_out_n_o <= 1'b0;
    end else begin
      if (!settle_cond)                 settle_cnt <= SCW'(SETTLE_TICKS);
      else if (tick && settle_cnt != '0) settle_cnt <= settle_cnt - SCW'(1);
      rst_out_n_o <= settle_cond && (settle_cnt == '0);
    end
  end

  p_line_low_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sysrst_line_i |=> (gate_en_o == '0)));

  p_fault_kills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_ok |=> (gate_en_o == '0)));

  p_enable_drop_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en_i |=> !rst_out_n_o));

  p_release_needs_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n_o |-> (&gate_en_o)));

  p_lockout_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SQ_IDLE) && lockout && !line_rise |=> (state != SQ_HOLD)));
endmodule

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seq_en;
  logic [3:0]  uv_ok;
  logic        ext_line;
  logic        line;
  logic [63:0] on_dly, off_dly;
  logic [3:0]  gate;
  logic        pull;
  logic        rst_out_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rise_t[4];
  int fall_t[4];
  logic [3:0] seen_rise;
  logic [3:0] prev_gate;
  bit done = 0;

  always #10 clk = ~clk;

  // shared line: external driver wired-AND with the block's own pull-down
  assign line = ext_line & ~pull;

  rail_seq_ctrl #(
    .NCH(NCH), .PRESCALE(4), .LOCKOUT_TICKS(8),
    .SETTLE_TICKS(12), .GLITCH_TICKS(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_en_i(seq_en), .uv_ok_i(uv_ok),
    .sysrst_line_i(line), .on_dly_i(on_dly), .off_dly_i(off_dly),
    .gate_full_i(gate), .gate_en_o(gate), .sysrst_pull_o(pull),
    .rst_out_n_o(rst_out_n)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (gate[i] && !prev_gate[i]) begin rise_t[i] = cyc; seen_rise[i] = 1'b1; end
      if (!gate[i] && prev_gate[i]) fall_t[i] = cyc;
    end
    prev_gate = gate;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gate(input int idx);
    while (!gate[idx]) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; seq_en = 0; uv_ok = 4'h0; ext_line = 1;
    prev_gate = 4'h0; seen_rise = 4'h0;
    // A=0, B=6, C=3, D=10 ticks on; A=9, B=2, C=6, D=0 ticks off
    on_dly  = {16'd10, 16'd3, 16'd6, 16'd0};
    off_dly = {16'd0, 16'd6, 16'd2, 16'd9};
    cycles(5);
    chk(gate == 4'h0, "R1 gates in reset", int'(gate), 0);
    chk(rst_out_n == 1'b0, "R1 reset output in reset", int'(rst_out_n), 0);
    rst_n = 1;
    cycles(3);
    chk(pull == 1'b1, "R1 pull while rails bad", int'(pull), 1);
    chk(gate == 4'h0, "R1 gates after reset", int'(gate), 0);
  endtask

  task automatic t_lockout_ramp;
    int t_uv;
    uv_ok = 4'hF;
    t_uv = cyc;
    cycles(6);
    seq_en = 1;
    cycles(42);
    chk(gate == 4'h0, "R3 enable ignored in lockout", int'(gate), 0);
    wait_gate(3);
    cycles(1);
    chk(gate == 4'hF, "R4 all gates on", int'(gate), 15);
    chk(rise_t[0] - t_uv >= 60 && rise_t[0] - t_uv <= 80, "R4 first rise after lockout and wait",
        rise_t[0] - t_uv, 70);
    chk(rise_t[2] - rise_t[0] >= 9 && rise_t[2] - rise_t[0] <= 14, "R4 C after A",
        rise_t[2] - rise_t[0], 12);
    chk(rise_t[1] - rise_t[2] >= 11 && rise_t[1] - rise_t[2] <= 13, "R4 B after C",
        rise_t[1] - rise_t[2], 12);
    chk(rise_t[3] - rise_t[1] >= 15 && rise_t[3] - rise_t[1] <= 17, "R4 D after B",
        rise_t[3] - rise_t[1], 16);
    cycles(29);
    chk(rst_out_n == 1'b0, "R7 reset held during settle", int'(rst_out_n), 0);
    cycles(30);
    chk(rst_out_n == 1'b1, "R7 reset released after settle", int'(rst_out_n), 1);
    chk(pull == 1'b0, "R11 no pull with rails good", int'(pull), 0);
  endtask

  task automatic t_shutdown;
    seq_en = 0;
    cycles(1);
    chk(rst_out_n == 1'b0, "R8 reset on enable drop", int'(rst_out_n), 0);
    cycles(60);
    chk(gate == 4'h0, "R5 all gates off", int'(gate), 0);
    chk(fall_t[3] < fall_t[1] && fall_t[1] < fall_t[2] && fall_t[2] < fall_t[0],
        "R5 order D,B,C,A", fall_t[0] - fall_t[3], 36);
    chk(fall_t[2] - fall_t[1] >= 15 && fall_t[2] - fall_t[1] <= 17, "R5 C after B",
        fall_t[2] - fall_t[1], 16);
    chk(fall_t[0] - fall_t[2] >= 11 && fall_t[0] - fall_t[2] <= 13, "R5 A after C",
        fall_t[0] - fall_t[2], 12);
  endtask

  task automatic t_cancel;
    seen_rise = 4'h0;
    seq_en = 1;
    wait_gate(2);
    cycles(2);
    seq_en = 0;
    cycles(80);
    chk(seen_rise[1] == 1'b0, "R6 B never rises", int'(seen_rise[1]), 0);
    chk(seen_rise[3] == 1'b0, "R6 D never rises", int'(seen_rise[3]), 0);
    chk(gate == 4'h0, "R6 all off after cancel", int'(gate), 0);
  endtask

  task automatic t_glitch;
    seq_en = 1;
    wait_gate(3);
    cycles(5);
    uv_ok[1] = 0;
    cycles(4);
    uv_ok[1] = 1;
    cycles(3);
    chk(gate == 4'hF, "R2 short dip ignored", int'(gate), 15);
    chk(pull == 1'b0, "R11 no pull on short dip", int'(pull), 0);
    uv_ok[1] = 0;
    cycles(25);
    chk(gate == 4'h0, "R2 long dip is fault", int'(gate), 0);
    chk(pull == 1'b1, "R11 pull during fault", int'(pull), 1);
    chk(rst_out_n == 1'b0, "R8 reset during fault", int'(rst_out_n), 0);
    uv_ok[1] = 1;
    cycles(12);
    chk(gate[0] == 1'b1, "R10 restart without wait after line rises", int'(gate[0]), 1);
    chk(gate[1] == 1'b0, "R10 later channel still counting", int'(gate[1]), 0);
  endtask

  task automatic t_sysrst;
    wait_gate(3);
    cycles(5);
    ext_line = 0;
    cycles(2);
    chk(gate == 4'h0, "R9 immediate latch-off", int'(gate), 0);
    cycles(20);
    chk(gate == 4'h0, "R9 stays off while line low", int'(gate), 0);
    chk(rst_out_n == 1'b0, "R9 reset while line low", int'(rst_out_n), 0);
    ext_line = 1;
    cycles(12);
    chk(gate[0] == 1'b1, "R10 rising edge bypasses wait", int'(gate[0]), 1);
    chk(gate[1] == 1'b0, "R10 B follows its own delay", int'(gate[1]), 0);
    seq_en = 0;
    cycles(60);
    chk(gate == 4'h0, "R5 off after final drop", int'(gate), 0);
  endtask

  initial begin
    t_reset();
    t_lockout_ramp();
    t_shutdown();
    t_cancel();
    t_glitch();
    t_sysrst();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule